// File: doc/BRIEF.md
# 16-bit Pipeline Decode and Branch-Resolve Stage

This block is the second stage of a five-stage, 16-bit, eight-register pipeline. Each cycle it takes the instruction word and its address from the fetch latch. It drives the three register read addresses and receives operand values that other logic has already forwarded. From these it builds the packet for the execute latch: an ALU operation, two operands, store data, a destination register and a memory-access code. The packet is registered inside this block, so it appears at the execute latch outputs one clock edge after the instruction is presented.

Branches and jumps complete here and never reach execute. For a branch-if-equal, the stage compares two registers and tells fetch what PC increment to use. For a jump-and-link, it redirects fetch to the value of a register and issues a write of the jump's own address into the link register. Both kinds send a bubble to execute. Load-upper-immediate uses no shifter. It is encoded as an AND of the immediate, already placed in the upper ten bits, against a fixed mask. Fetch-side outputs are combinational in the same cycle.

Top module: `dec16_stage`

## Requirements
- R1: While rst_n is low, and after its release until the first instruction is latched, every execute-latch output is zero.
- R2: Opcode field is bits 15:13, register A is 12:10, register B is 9:7 and register C is 2:0. Opcode 000 (add) gives ALU code 00 and opcode 010 (nand) gives ALU code 01. For both, operand A is the value of register B, operand B is the value of register C, the destination is register A, the memory code is 00 (none) and the store data is zero.
- R3: Opcodes 001 (addi), 101 (lw) and 100 (sw) give ALU code 00. Operand A is register B and operand B is bits 6:0 sign-extended to 16 bits. addi has memory code 00 and destination A. lw has memory code 01 and destination A. sw has memory code 10, destination 0 and store data equal to the value of register A. For all other instructions the store data is zero.
- R4: Opcode 011 (lui) gives ALU code 10, operand A equal to bits 9:0 placed in bits 15:6 with zeros below, operand B equal to 0xFFC0, destination A and memory code 00.
- R5: Opcode 110 (beq) drives pc_step with bits 6:0 sign-extended when register A equals register B, and with 1 otherwise. Every other valid instruction drives pc_step to 1.
- R6: Opcode 111 (jalr) raises pc_redirect with pc_target equal to the value of register B. It raises link_we with link_addr set to register A and link_data set to fetch_pc, unless register A is 0. For every other case, pc_redirect, pc_target, link_we, link_addr and link_data are zero.
- R7: beq and jalr place a bubble in the execute latch: all of its outputs are zero.
- R8: When fetch_valid is low, pc_step is 1, the other fetch-side and link outputs are zero, and the next execute latch contents are all zero.
- R9: A read of register 0 yields zero, whatever value arrives on its read-data input.
- R10: Fetch-side and link outputs respond in the same cycle as the instruction. Execute-latch outputs take the decoded packet at the next rising clk edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch latch holds an instruction |
| fetch_instr | input | 16 | Instruction word from the fetch latch |
| fetch_pc | input | 16 | Address of that instruction |
| rd_addr_a | output | 3 | Read address, register A field |
| rd_addr_b | output | 3 | Read address, register B field |
| rd_addr_c | output | 3 | Read address, register C field |
| rd_data_a | input | 16 | Forwarded value for rd_addr_a |
| rd_data_b | input | 16 | Forwarded value for rd_addr_b |
| rd_data_c | input | 16 | Forwarded value for rd_addr_c |
| ex_alu_op | output | 2 | Execute latch: ALU code (00 add, 01 nand, 10 and) |
| ex_opnd_a | output | 16 | Execute latch: first operand |
| ex_opnd_b | output | 16 | Execute latch: second operand |
| ex_store_data | output | 16 | Execute latch: data for a store |
| ex_dest | output | 3 | Execute latch: destination register |
| ex_mem_op | output | 2 | Execute latch: memory code (00 none, 01 load, 10 store) |
| pc_step | output | 16 | PC increment for fetch |
| pc_redirect | output | 1 | Fetch must load pc_target |
| pc_target | output | 16 | Jump destination |
| link_we | output | 1 | Register write of the link address |
| link_addr | output | 3 | Link register |
| link_data | output | 16 | Link value (the jump's own address) |

## Verification
The fetch-side and link outputs are combinational, so the bench checks them 1 ns after driving an instruction on a falling edge, before any clock edge. The execute-latch outputs are due one register later, so they are checked 1 ns after the following rising edge, and this covers R10 for every instruction. The sweep covers all opcodes crossed with every register A and B. The register model places a nonzero value on reads of register 0 and duplicates one value, so that both branch outcomes occur and zero masking is visible. Reset and the invalid-fetch case are checked at the same two sample points.

// File: rtl/dec16_pkg.sv
package dec16_pkg;
  localparam int WORD_W  = 16;
  localparam int REG_AW  = 3;
  localparam int IMMS_W  = 7;
  localparam int IMMU_W  = 10;
  localparam int OPC_W   = 3;
  localparam int ALU_W   = 2;
  localparam int MEM_W   = 2;
  localparam logic [WORD_W-1:0] UPPER_MASK = 16'hFFC0;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD  = 3'b000,
    OPC_ADDI = 3'b001,
    OPC_NAND = 3'b010,
    OPC_LUI  = 3'b011,
    OPC_SW   = 3'b100,
    OPC_LW   = 3'b101,
    OPC_BEQ  = 3'b110,
    OPC_JALR = 3'b111
  } opc_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD  = 2'b00,
    ALU_NAND = 2'b01,
    ALU_AND  = 2'b10
  } alu_e;

  typedef enum logic [MEM_W-1:0] {
    MEM_NONE  = 2'b00,
    MEM_LOAD  = 2'b01,
    MEM_STORE = 2'b10
  } mem_e;

  typedef struct packed {
    alu_e              alu;
    logic [WORD_W-1:0] opa;
    logic [WORD_W-1:0] opb;
    logic [WORD_W-1:0] sdata;
    logic [REG_AW-1:0] dest;
    mem_e              mem;
  } ex_pkt_t;

  function automatic logic [WORD_W-1:0] sext_imm(input logic [IMMS_W-1:0] imm);
    return {{(WORD_W-IMMS_W){imm[IMMS_W-1]}}, imm};
  endfunction

  function automatic logic [WORD_W-1:0] upper_place(input logic [IMMU_W-1:0] imm);
    return {imm, {(WORD_W-IMMU_W){1'b0}}};
  endfunction
endpackage

// File: rtl/dec16_fields.sv
module dec16_fields
  import dec16_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = REG_AW
) (
  input  logic [W-1:0]  instr,
  input  logic [W-1:0]  raw_a,
  input  logic [W-1:0]  raw_b,
  input  logic [W-1:0]  raw_c,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic [AW-1:0] addr_c,
  output opc_e          opc,
  output logic [W-1:0]  imm_s,
  output logic [W-1:0]  imm_u,
  output logic [W-1:0]  val_a,
  output logic [W-1:0]  val_b,
  output logic [W-1:0]  val_c
);
  localparam int NPORT = 3;
  localparam int A_LSB = W - OPC_W - AW;
  localparam int B_LSB = A_LSB - AW;

  logic [AW-1:0] addr_v [NPORT];
  logic [W-1:0]  raw_v  [NPORT];
  logic [W-1:0]  val_v  [NPORT];

  assign opc    = opc_e'(instr[W-1 -: OPC_W]);
  assign addr_a = instr[A_LSB +: AW];
  assign addr_b = instr[B_LSB +: AW];
  assign addr_c = instr[AW-1:0];
  assign imm_s  = sext_imm(instr[IMMS_W-1:0]);
  assign imm_u  = upper_place(instr[IMMU_W-1:0]);

  assign addr_v[0] = addr_a;
  assign addr_v[1] = addr_b;
  assign addr_v[2] = addr_c;
  assign raw_v[0]  = raw_a;
  assign raw_v[1]  = raw_b;
  assign raw_v[2]  = raw_c;

  for (genvar g = 0; g < NPORT; g++) begin : g_zero_mask
    assign val_v[g] = (addr_v[g] == '0) ? '0 : raw_v[g];
  end

  assign val_a = val_v[0];
  assign val_b = val_v[1];
  assign val_c = val_v[2];
endmodule

// File: rtl/dec16_ctrl.sv
module dec16_ctrl
  import dec16_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = REG_AW
) (
  input  logic          valid,
  input  opc_e          opc,
  input  logic [AW-1:0] addr_a,
  input  logic [W-1:0]  val_a,
  input  logic [W-1:0]  val_b,
  input  logic [W-1:0]  val_c,
  input  logic [W-1:0]  imm_s,
  input  logic [W-1:0]  imm_u,
  output ex_pkt_t       pkt
);
  always_comb begin
    pkt = '0;
    if (valid) begin
      case (opc)
        OPC_ADD, OPC_NAND: begin
          pkt.alu  = (opc == OPC_NAND) ? ALU_NAND : ALU_ADD;
          pkt.opa  = val_b;
          pkt.opb  = val_c;
          pkt.dest = addr_a;
        end
        OPC_ADDI, OPC_LW, OPC_SW: begin
          pkt.alu = ALU_ADD;
          pkt.opa = val_b;
          pkt.opb = imm_s;
          if (opc == OPC_SW) begin
            pkt.mem   = MEM_STORE;
            pkt.sdata = val_a;
          end else begin
            pkt.dest = addr_a;
            pkt.mem  = (opc == OPC_LW) ? MEM_LOAD : MEM_NONE;
          end
        end
        OPC_LUI: begin
          pkt.alu  = ALU_AND;
          pkt.opa  = imm_u;
          pkt.opb  = UPPER_MASK;
          pkt.dest = addr_a;
        end
        default: pkt = '0;
      endcase
    end
  end
endmodule

// File: rtl/dec16_flow.sv
module dec16_flow
  import dec16_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = REG_AW
) (
  input  logic          valid,
  input  opc_e          opc,
  input  logic [AW-1:0] addr_a,
  input  logic [W-1:0]  val_a,
  input  logic [W-1:0]  val_b,
  input  logic [W-1:0]  imm_s,
  input  logic [W-1:0]  pc,
  output logic          equal,
  output logic [W-1:0]  step,
  output logic          redirect,
  output logic [W-1:0]  target,
  output logic          lk_we,
  output logic [AW-1:0] lk_addr,
  output logic [W-1:0]  lk_data
);
  localparam logic [W-1:0] STEP_ONE = W'(1);

  assign equal = (val_a == val_b);

  always_comb begin
    step     = STEP_ONE;
    redirect = 1'b0;
    target   = '0;
    lk_we    = 1'b0;
    lk_addr  = '0;
    lk_data  = '0;
    if (valid) begin
      if (opc == OPC_BEQ && equal) step = imm_s;
      if (opc == OPC_JALR) begin
        redirect = 1'b1;
        target   = val_b;
        if (addr_a != '0) begin
          lk_we   = 1'b1;
          lk_addr = addr_a;
          lk_data = pc;
        end
      end
    end
  end
endmodule

// File: rtl/dec16_stage.sv
module dec16_stage
  import dec16_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [W-1:0]  fetch_instr,
  input  logic [W-1:0]  fetch_pc,
  output logic [AW-1:0] rd_addr_a,
  output logic [AW-1:0] rd_addr_b,
  output logic [AW-1:0] rd_addr_c,
  input  logic [W-1:0]  rd_data_a,
  input  logic [W-1:0]  rd_data_b,
  input  logic [W-1:0]  rd_data_c,
  output logic [1:0]    ex_alu_op,
  output logic [W-1:0]  ex_opnd_a,
  output logic [W-1:0]  ex_opnd_b,
  output logic [W-1:0]  ex_store_data,
  output logic [AW-1:0] ex_dest,
  output logic [1:0]    ex_mem_op,
  output logic [W-1:0]  pc_step,
  output logic          pc_redirect,
  output logic [W-1:0]  pc_target,
  output logic          link_we,
  output logic [AW-1:0] link_addr,
  output logic [W-1:0]  link_data
);
  opc_e         opc;
  logic [W-1:0] imm_s, imm_u;
  logic [W-1:0] src_val_a, src_val_b, src_val_c;
  logic         beq_equal;
  ex_pkt_t      pkt_next, pkt_q;

  dec16_fields #(.W(W), .AW(AW)) u_fields (
    .instr (fetch_instr),
    .raw_a (rd_data_a),
    .raw_b (rd_data_b),
    .raw_c (rd_data_c),
    .addr_a(rd_addr_a),
    .addr_b(rd_addr_b),
    .addr_c(rd_addr_c),
    .opc   (opc),
    .imm_s (imm_s),
    .imm_u (imm_u),
    .val_a (src_val_a),
    .val_b (src_val_b),
    .val_c (src_val_c)
  );

  dec16_ctrl #(.W(W), .AW(AW)) u_ctrl (
    .valid (fetch_valid),
    .opc   (opc),
    .addr_a(rd_addr_a),
    .val_a (src_val_a),
    .val_b (src_val_b),
    .val_c (src_val_c),
    .imm_s (imm_s),
    .imm_u (imm_u),
    .pkt   (pkt_next)
  );

  dec16_flow #(.W(W), .AW(AW)) u_flow (
    .valid   (fetch_valid),
    .opc     (opc),
    .addr_a  (rd_addr_a),
    .val_a   (src_val_a),
    .val_b   (src_val_b),
    .imm_s   (imm_s),
    .pc      (fetch_pc),
    .equal   (beq_equal),
    .step    (pc_step),
    .redirect(pc_redirect),
    .target  (pc_target),
    .lk_we   (link_we),
    .lk_addr (link_addr),
    .lk_data (link_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pkt_q <= '0;
    else        pkt_q <= pkt_next;
  end

  assign ex_alu_op     = pkt_q.alu;
  assign ex_opnd_a     = pkt_q.opa;
  assign ex_opnd_b     = pkt_q.opb;
  assign ex_store_data = pkt_q.sdata;
  assign ex_dest       = pkt_q.dest;
  assign ex_mem_op     = pkt_q.mem;
endmodule

// File: rtl/dec16_sva.sv
module dec16_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_valid,
  input logic [15:0] fetch_instr,
  input logic [2:0]  rd_addr_a,
  input logic [15:0] src_val_a,
  input logic        beq_equal,
  input logic [1:0]  ex_alu_op,
  input logic [2:0]  ex_dest,
  input logic [1:0]  ex_mem_op,
  input logic [15:0] ex_opnd_a,
  input logic [15:0] pc_step,
  input logic        pc_redirect
);
  // R8: idle fetch latch keeps the default increment and no redirect
  assert_idle_flow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (pc_step == 16'd1) && !pc_redirect);

  // R7: control-transfer instructions leave a bubble in the execute latch
  assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_instr[15:14] == 2'b11) |=>
      (ex_alu_op == 2'b00) && (ex_dest == 3'd0) && (ex_mem_op == 2'b00) && (ex_opnd_a == 16'd0));

  // R6: only a valid jalr redirects fetch
  assert_redirect_jalr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redirect |-> fetch_valid && (fetch_instr[15:13] == 3'b111));

  // R5: non-branch instructions step by one; a branch whose compare fails also steps by one
  assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && (fetch_instr[15:13] != 3'b110 || !beq_equal)) |-> (pc_step == 16'd1));

  // R3: a store carries no destination and the store memory code
  assert_store_nodest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_instr[15:13] == 3'b100) |=> (ex_mem_op == 2'b10) && (ex_dest == 3'd0));

  // R9: register 0 reads as zero
  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == 3'd0) |-> (src_val_a == 16'd0));
endmodule

bind dec16_stage dec16_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_valid(fetch_valid),
  .fetch_instr(fetch_instr),
  .rd_addr_a  (rd_addr_a),
  .src_val_a  (src_val_a),
  .beq_equal  (beq_equal),
  .ex_alu_op  (ex_alu_op),
  .ex_dest    (ex_dest),
  .ex_mem_op  (ex_mem_op),
  .ex_opnd_a  (ex_opnd_a),
  .pc_step    (pc_step),
  .pc_redirect(pc_redirect)
);

// File: tb/dec16_stage_bench.sv
`timescale 1ns/1ps
module dec16_stage_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_instr = '0;
  logic [15:0] fetch_pc = '0;
  logic [2:0]  rd_addr_a, rd_addr_b, rd_addr_c;
  logic [15:0] rd_data_a, rd_data_b, rd_data_c;
  logic [1:0]  ex_alu_op, ex_mem_op;
  logic [15:0] ex_opnd_a, ex_opnd_b, ex_store_data;
  logic [2:0]  ex_dest;
  logic [15:0] pc_step, pc_target, link_data;
  logic        pc_redirect, link_we;
  logic [2:0]  link_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // Register model: register 0 deliberately drives garbage; 3 and 5 share a value; 6 holds zero.
  function automatic logic [15:0] reg_file(input logic [2:0] i);
    case (i)
      3'd0: return 16'hDEAD;
      3'd1: return 16'h0005;
      3'd2: return 16'hFFF3;
      3'd3: return 16'h1234;
      3'd4: return 16'h8001;
      3'd5: return 16'h1234;
      3'd6: return 16'h0000;
      default: return 16'h7FFF;
    endcase
  endfunction

  function automatic logic [15:0] seen(input logic [2:0] i);
    return (i == 3'd0) ? 16'h0000 : reg_file(i);
  endfunction

  function automatic logic [15:0] sx7(input logic [15:0] word);
    int v;
    v = int'(word & 16'h007F);
    if (v >= 64) v = v - 128;
    return 16'(v);
  endfunction

  assign rd_data_a = reg_file(rd_addr_a);
  assign rd_data_b = reg_file(rd_addr_b);
  assign rd_data_c = reg_file(rd_addr_c);

  dec16_stage u_dec16_stage (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_instr(fetch_instr), .fetch_pc(fetch_pc),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_addr_c(rd_addr_c),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_data_c(rd_data_c),
    .ex_alu_op(ex_alu_op), .ex_opnd_a(ex_opnd_a), .ex_opnd_b(ex_opnd_b),
    .ex_store_data(ex_store_data), .ex_dest(ex_dest), .ex_mem_op(ex_mem_op),
    .pc_step(pc_step), .pc_redirect(pc_redirect), .pc_target(pc_target),
    .link_we(link_we), .link_addr(link_addr), .link_data(link_data)
  );

  task automatic check_ex(input string tag, input logic [54:0] exp);
    logic [54:0] act;
    act = {ex_alu_op, ex_opnd_a, ex_opnd_b, ex_store_data, ex_dest, ex_mem_op};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s execute latch: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_flow(input string tag, input logic [52:0] exp);
    logic [52:0] act;
    act = {pc_step, pc_redirect, pc_target, link_we, link_addr, link_data};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s fetch/link: actual %h expected %h", tag, act, exp);
    end
  endtask

  localparam logic [52:0] FLOW_IDLE = {16'd1, 1'b0, 16'd0, 1'b0, 3'd0, 16'd0};

  initial begin
    // R1: reset clears the execute latch even with a valid add presented
    fetch_valid = 1'b1;
    fetch_instr = {3'b000, 3'd1, 3'd3, 4'd0, 3'd4};
    repeat (2) @(posedge clk);
    #1 check_ex("R1 during reset", 55'd0);
    @(negedge clk);
    fetch_valid = 1'b0;
    rst_n = 1'b1;
    #1 check_ex("R1 after release", 55'd0);
    check_flow("R8 idle fetch", FLOW_IDLE);

    // Sweep all opcodes against all register A / B choices.
    for (int op = 0; op < 8; op++) begin
      for (int ra = 0; ra < 8; ra++) begin
        for (int rb = 0; rb < 8; rb++) begin
          logic [6:0]  low;
          logic [15:0] ins, pc, va, vb, vc, imm, upr;
          logic [54:0] exp_ex;
          logic [52:0] exp_fl;
          string       tag;
          low = 7'((ra * 37 + rb * 11 + op * 5 + 3) % 128);
          ins = {3'(op), 3'(ra), 3'(rb), low};
          pc  = 16'((op * 64 + ra * 8 + rb) * 3 + 16'h0100);
          va  = seen(3'(ra));
          vb  = seen(3'(rb));
          vc  = seen(low[2:0]);
          imm = sx7(ins);
          upr = (ins & 16'h03FF) << 6;
          exp_fl = FLOW_IDLE;
          exp_ex = '0;
          case (op)
            0: begin tag = "R2 add";  exp_ex = {2'b00, vb, vc, 16'd0, 3'(ra), 2'b00}; end
            2: begin tag = "R2 nand"; exp_ex = {2'b01, vb, vc, 16'd0, 3'(ra), 2'b00}; end
            1: begin tag = "R3 addi"; exp_ex = {2'b00, vb, imm, 16'd0, 3'(ra), 2'b00}; end
            5: begin tag = "R3 lw";   exp_ex = {2'b00, vb, imm, 16'd0, 3'(ra), 2'b01}; end
            4: begin tag = "R3 sw";   exp_ex = {2'b00, vb, imm, va, 3'd0, 2'b10}; end
            3: begin tag = "R4 lui";  exp_ex = {2'b10, upr, 16'hFFC0, 16'd0, 3'(ra), 2'b00}; end
            6: begin
              tag = (va == vb) ? "R5 beq taken" : "R5 beq not taken";
              exp_fl = {((va == vb) ? imm : 16'd1), 1'b0, 16'd0, 1'b0, 3'd0, 16'd0};
            end
            default: begin
              tag = "R6 jalr";
              exp_fl = (ra == 0) ? {16'd1, 1'b1, vb, 1'b0, 3'd0, 16'd0}
                                 : {16'd1, 1'b1, vb, 1'b1, 3'(ra), pc};
            end
          endcase
          @(negedge clk);
          fetch_valid = 1'b1;
          fetch_instr = ins;
          fetch_pc    = pc;
          #1 check_flow($sformatf("%s R9 R10 ra=%0d rb=%0d", tag, ra, rb), exp_fl);
          @(posedge clk);
          #1 check_ex($sformatf("%s R7 R9 R10 ra=%0d rb=%0d", tag, ra, rb), exp_ex);
        end
      end
    end

    // R8: invalid fetch with a jalr word on the bus does nothing and drains the latch
    @(negedge clk);
    fetch_valid = 1'b0;
    fetch_instr = {3'b111, 3'd7, 3'd4, 7'd0};
    #1 check_flow("R8 invalid jalr word", FLOW_IDLE);
    @(posedge clk);
    #1 check_ex("R8 invalid drains latch", 55'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule